// File: doc/BRIEF.md
# Host Memory Region Router

This block sits on the host side of a memory controller. It sorts every 32-bit host physical address into one of three targets: local DRAM, PCI memory, or the boot flash window at the very top of the address space. It also says whether the access may be cached. The decode is combinational, so the selects and the cacheable flag follow the address in the same cycle.

A small configuration register feeds the decode. It holds the top of DRAM in 1 MB units and two cacheability enables for the 64 KB system BIOS segment at F0000h–FFFFFh, one for reads and one for writes. The register loads when `cfg_we` is high at a rising clock edge. Top-of-DRAM values outside 2..192 are clamped when they are written. The flash window needs no configuration, so the processor's first fetch after reset reaches PCI.

Top module: `hmr_router`

## Requirements
- R1: Addresses FFF80000h–FFFFFFFFh (address bits [31:19] all ones) assert only `sel_flash`, with `cacheable` low, whatever the configuration holds, including straight after reset.
- R2: Addresses from 100000h up to but not including (top of DRAM × 1 MB) assert `sel_dram` with `cacheable` high.
- R3: Addresses from (top of DRAM × 1 MB) up to FFF7FFFFh assert `sel_pci` with `cacheable` low.
- R4: A top-of-DRAM value above 192 is stored as 192, so addresses at 0C000000h and above never select DRAM.
- R5: A top-of-DRAM value below 2 is stored as 2. The reset value is 2, with both BIOS enables clear.
- R6: A read (`is_write` = 0) in F0000h–FFFFFh selects DRAM and is cacheable when the read enable is set. Otherwise it selects PCI and is not cacheable.
- R7: A write (`is_write` = 1) in F0000h–FFFFFh follows the same rule using the write enable alone.
- R8: Addresses 000000h–0EFFFFh select DRAM and are cacheable.
- R9: Exactly one of `sel_dram`, `sel_pci` and `sel_flash` is high for every address.
- R10: Configuration inputs have no effect unless `cfg_we` is high at a rising clock edge. A write affects decodes from the cycle after that edge.
- R11: The outputs follow a change of `addr` or `is_write` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the configuration at this clock edge |
| cfg_top_mb | input | 8 | New top of DRAM in MB (clamped to 2..192) |
| cfg_bios_rd_cache | input | 1 | New read enable for the BIOS segment |
| cfg_bios_wr_cache | input | 1 | New write enable for the BIOS segment |
| addr | input | 32 | Host physical address |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| sel_dram | output | 1 | Access goes to local DRAM |
| sel_pci | output | 1 | Access goes to PCI memory |
| sel_flash | output | 1 | Access goes to the boot flash window on PCI |
| cacheable | output | 1 | Access may be cached |

## Verification
The hardest cases are the one-megabyte edges around the programmed top of DRAM and around the flash window, because uniformly random addresses almost never fall on them. Random addresses are therefore drawn with a bias: some are placed within a few bytes of the current top, some at the flash base, and some in the BIOS segment. Those in the BIOS segment are mixed with random read/write direction and random enable settings. Directed probes cover the clamp edges (0, 1, 193 and 255 written). They also cover configuration inputs that change while `cfg_we` is low.

// File: rtl/hmr_pkg.sv
package hmr_pkg;

    typedef enum logic [1:0] {
        TGT_DRAM  = 2'd0,
        TGT_PCI   = 2'd1,
        TGT_FLASH = 2'd2
    } target_e;

    localparam int unsigned NUM_TGT = 3;

    typedef struct packed {
        target_e tgt;
        logic    cacheable;
    } route_t;

endpackage

// File: rtl/hmr_cfg_reg.sv
module hmr_cfg_reg #(
    parameter int unsigned TOP_W  = 8,
    parameter int unsigned MIN_MB = 2,
    parameter int unsigned MAX_MB = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TOP_W-1:0] top_in,
    input  logic             rd_cache_in,
    input  logic             wr_cache_in,
    output logic [TOP_W-1:0] top_q,
    output logic             rd_cache_q,
    output logic             wr_cache_q
);
    localparam logic [TOP_W-1:0] MIN_V = TOP_W'(MIN_MB);
    localparam logic [TOP_W-1:0] MAX_V = TOP_W'(MAX_MB);

    typedef struct packed {
        logic [TOP_W-1:0] top;
        logic             rd_cache;
        logic             wr_cache;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            if (top_in > MAX_V)      cfg_d.top = MAX_V;
            else if (top_in < MIN_V) cfg_d.top = MIN_V;
            else                     cfg_d.top = top_in;
            cfg_d.rd_cache = rd_cache_in;
            cfg_d.wr_cache = wr_cache_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.top      <= MIN_V;
            cfg_q.rd_cache <= 1'b0;
            cfg_q.wr_cache <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign top_q      = cfg_q.top;
    assign rd_cache_q = cfg_q.rd_cache;
    assign wr_cache_q = cfg_q.wr_cache;
endmodule

// File: rtl/hmr_field_match.sv
module hmr_field_match #(
    parameter int unsigned W       = 4,
    parameter logic [W-1:0] PATTERN = '1
) (
    input  logic [W-1:0] field,
    output logic         hit
);
    assign hit = (field == PATTERN);
endmodule

// File: rtl/hmr_decode.sv
module hmr_decode
    import hmr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned SEG_SHIFT   = 16,
    parameter int unsigned MB_SHIFT    = 20,
    parameter int unsigned FLASH_SHIFT = 19,
    parameter int unsigned TOP_W       = 8
) (
    input  logic [ADDR_W-SEG_SHIFT-1:0] addr_hi,
    input  logic                        is_write,
    input  logic [TOP_W-1:0]            top_mb,
    input  logic                        rd_cache,
    input  logic                        wr_cache,
    output route_t                      route
);
    localparam int unsigned HI_W    = ADDR_W - SEG_SHIFT;
    localparam int unsigned MBF_W   = ADDR_W - MB_SHIFT;
    localparam int unsigned FLASH_W = ADDR_W - FLASH_SHIFT;
    localparam int unsigned SUB_W   = MB_SHIFT - SEG_SHIFT;

    logic [MBF_W-1:0] mb_idx;
    logic [MBF_W-1:0] top_ext;
    logic             in_flash;
    logic             in_first_mb;
    logic             in_bios_seg;
    logic             bios_en;

    assign mb_idx  = addr_hi[HI_W-1 -: MBF_W];
    assign top_ext = MBF_W'(top_mb);

    hmr_field_match #(.W(FLASH_W), .PATTERN('1)) u_flash_match (
        .field (addr_hi[HI_W-1 -: FLASH_W]),
        .hit   (in_flash)
    );

    hmr_field_match #(.W(MBF_W), .PATTERN('0)) u_low_match (
        .field (mb_idx),
        .hit   (in_first_mb)
    );

    logic seg_top;
    hmr_field_match #(.W(SUB_W), .PATTERN('1)) u_seg_match (
        .field (addr_hi[SUB_W-1:0]),
        .hit   (seg_top)
    );

    assign in_bios_seg = in_first_mb && seg_top;
    assign bios_en     = is_write ? wr_cache : rd_cache;

    always_comb begin
        route_t route_d;
        if (in_flash) begin
            route_d.tgt       = TGT_FLASH;
            route_d.cacheable = 1'b0;
        end else if (in_bios_seg) begin
            route_d.tgt       = bios_en ? TGT_DRAM : TGT_PCI;
            route_d.cacheable = bios_en;
        end else if (in_first_mb || (mb_idx < top_ext)) begin
            route_d.tgt       = TGT_DRAM;
            route_d.cacheable = 1'b1;
        end else begin
            route_d.tgt       = TGT_PCI;
            route_d.cacheable = 1'b0;
        end
        route = route_d;
    end
endmodule

// File: rtl/hmr_router.sv
module hmr_router
    import hmr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned SEG_SHIFT   = 16,
    parameter int unsigned MB_SHIFT    = 20,
    parameter int unsigned FLASH_SHIFT = 19,
    parameter int unsigned TOP_W       = 8,
    parameter int unsigned MIN_MB      = 2,
    parameter int unsigned MAX_MB      = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [TOP_W-1:0]  cfg_top_mb,
    input  logic              cfg_bios_rd_cache,
    input  logic              cfg_bios_wr_cache,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic              sel_dram,
    output logic              sel_pci,
    output logic              sel_flash,
    output logic              cacheable
);
    logic [TOP_W-1:0]   top_mb_q;
    logic               rd_cache_q;
    logic               wr_cache_q;
    route_t             route;
    logic [NUM_TGT-1:0] sel_vec;
    logic               unused_low_bits;

    assign unused_low_bits = ^addr[SEG_SHIFT-1:0];

    hmr_cfg_reg #(
        .TOP_W  (TOP_W),
        .MIN_MB (MIN_MB),
        .MAX_MB (MAX_MB)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cfg_we),
        .top_in      (cfg_top_mb),
        .rd_cache_in (cfg_bios_rd_cache),
        .wr_cache_in (cfg_bios_wr_cache),
        .top_q       (top_mb_q),
        .rd_cache_q  (rd_cache_q),
        .wr_cache_q  (wr_cache_q)
    );

    hmr_decode #(
        .ADDR_W      (ADDR_W),
        .SEG_SHIFT   (SEG_SHIFT),
        .MB_SHIFT    (MB_SHIFT),
        .FLASH_SHIFT (FLASH_SHIFT),
        .TOP_W       (TOP_W)
    ) u_decode (
        .addr_hi  (addr[ADDR_W-1:SEG_SHIFT]),
        .is_write (is_write),
        .top_mb   (top_mb_q),
        .rd_cache (rd_cache_q),
        .wr_cache (wr_cache_q),
        .route    (route)
    );

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_sel
        assign sel_vec[t] = (route.tgt == target_e'(t));
    end

    assign sel_dram  = sel_vec[TGT_DRAM];
    assign sel_pci   = sel_vec[TGT_PCI];
    assign sel_flash = sel_vec[TGT_FLASH];
    assign cacheable = route.cacheable;
endmodule

// File: rtl/hmr_router_chk.sv
module hmr_router_chk #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned SEG_SHIFT   = 16,
    parameter int unsigned MB_SHIFT    = 20,
    parameter int unsigned FLASH_SHIFT = 19,
    parameter int unsigned TOP_W       = 8,
    parameter int unsigned MIN_MB      = 2,
    parameter int unsigned MAX_MB      = 192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] addr,
    input logic              is_write,
    input logic              sel_dram,
    input logic              sel_pci,
    input logic              sel_flash,
    input logic              cacheable,
    input logic [TOP_W-1:0]  top_mb_q,
    input logic              rd_cache_q,
    input logic              wr_cache_q
);
    logic [ADDR_W-MB_SHIFT-1:0] mb_field;
    logic                       flash_zone;
    logic                       seg_zone;

    assign mb_field   = addr[ADDR_W-1:MB_SHIFT];
    assign flash_zone = &addr[ADDR_W-1:FLASH_SHIFT];
    assign seg_zone   = (mb_field == '0) && (&addr[MB_SHIFT-1:SEG_SHIFT]);

    assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_dram, sel_pci, sel_flash}) == 1);

    assert_flash_to_pci_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flash_zone |-> (sel_flash && !cacheable));

    assert_dram_cached_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_dram |-> cacheable);

    assert_pci_uncached_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pci |-> !cacheable);

    assert_no_dram_above_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mb_field >= (ADDR_W-MB_SHIFT)'(MAX_MB)) && !flash_zone) |-> !sel_dram);

    assert_top_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mb_q >= TOP_W'(MIN_MB)) && (top_mb_q <= TOP_W'(MAX_MB)));

    assert_seg_read_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_zone && !is_write && !rd_cache_q) |-> sel_pci);

    assert_seg_write_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_zone && is_write && !wr_cache_q) |-> sel_pci);

    assert_low_mem_dram_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mb_field == '0) && !seg_zone) |-> (sel_dram && cacheable));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(top_mb_q) && $stable(rd_cache_q) && $stable(wr_cache_q));
endmodule

bind hmr_router hmr_router_chk #(
    .ADDR_W      (ADDR_W),
    .SEG_SHIFT   (SEG_SHIFT),
    .MB_SHIFT    (MB_SHIFT),
    .FLASH_SHIFT (FLASH_SHIFT),
    .TOP_W       (TOP_W),
    .MIN_MB      (MIN_MB),
    .MAX_MB      (MAX_MB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .addr       (addr),
    .is_write   (is_write),
    .sel_dram   (sel_dram),
    .sel_pci    (sel_pci),
    .sel_flash  (sel_flash),
    .cacheable  (cacheable),
    .top_mb_q   (top_mb_q),
    .rd_cache_q (rd_cache_q),
    .wr_cache_q (wr_cache_q)
);

// File: tb/hmr_router_tb.sv
module hmr_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_top_mb = 8'd0;
    logic        cfg_bios_rd_cache = 1'b0;
    logic        cfg_bios_wr_cache = 1'b0;
    logic [31:0] addr = 32'd0;
    logic        is_write = 1'b0;
    logic        sel_dram, sel_pci, sel_flash, cacheable;

    int checks = 0;
    int fails  = 0;

    int unsigned m_top = 2;
    logic        m_rd  = 1'b0;
    logic        m_wr  = 1'b0;

    always #2 clk = ~clk;

    hmr_router u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_we            (cfg_we),
        .cfg_top_mb        (cfg_top_mb),
        .cfg_bios_rd_cache (cfg_bios_rd_cache),
        .cfg_bios_wr_cache (cfg_bios_wr_cache),
        .addr              (addr),
        .is_write          (is_write),
        .sel_dram          (sel_dram),
        .sel_pci           (sel_pci),
        .sel_flash         (sel_flash),
        .cacheable         (cacheable)
    );

    function automatic int unsigned clamp_top(input int unsigned v);
        if (v > 192) return 192;
        if (v < 2)   return 2;
        return v;
    endfunction

    // expected {dram, pci, flash, cacheable}
    function automatic logic [3:0] expect_route(input logic [31:0] a, input logic w);
        logic en;
        if (a >= 32'hFFF8_0000) return 4'b0010;
        if (a < 32'h0010_0000) begin
            if (a >= 32'h000F_0000) begin
                en = w ? m_wr : m_rd;
                return en ? 4'b1001 : 4'b0100;
            end
            return 4'b1001;
        end
        if ((a >> 20) < m_top) return 4'b1001;
        return 4'b0100;
    endfunction

    task automatic probe(input logic [31:0] a, input logic w, input string req);
        logic [3:0] got, exp;
        addr     = a;
        is_write = w;
        #1;
        got = {sel_dram, sel_pci, sel_flash, cacheable};
        exp = expect_route(a, w);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h wr=%0b got=%b expected=%b", req, a, w, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] top, input logic rd, input logic wr);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_top_mb = top;
        cfg_bios_rd_cache = rd;
        cfg_bios_wr_cache = wr;
        @(negedge clk);
        cfg_we = 1'b0;
        m_top = clamp_top(top);
        m_rd = rd;
        m_wr = wr;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not finish (got hang, expected completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a;
        int unsigned kind;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R1 reset vector, R5 default top of 2 MB, BIOS enables clear
        probe(32'hFFFF_FFF0, 1'b0, "R1");
        probe(32'h001F_FFFF, 1'b0, "R5");
        probe(32'h0020_0000, 1'b0, "R5");
        probe(32'h000F_FFF0, 1'b0, "R6");
        probe(32'h000F_0000, 1'b1, "R7");
        probe(32'h0000_0000, 1'b0, "R8");
        probe(32'h000E_FFFF, 1'b1, "R8");

        // R2/R3 boundaries at 64 MB
        cfg_write(8'd64, 1'b0, 1'b0);
        probe(32'h0010_0000, 1'b0, "R2");
        probe(32'h03FF_FFFF, 1'b1, "R2");
        probe(32'h0400_0000, 1'b0, "R3");
        probe(32'hFFF7_FFFF, 1'b0, "R3");
        probe(32'hFFF8_0000, 1'b1, "R1");

        // R4 clamp above maximum
        cfg_write(8'd255, 1'b0, 1'b0);
        probe(32'h0BFF_FFFF, 1'b0, "R4");
        probe(32'h0C00_0000, 1'b0, "R4");
        cfg_write(8'd193, 1'b0, 1'b0);
        probe(32'h0C00_0000, 1'b1, "R4");
        cfg_write(8'd192, 1'b0, 1'b0);
        probe(32'h0BF0_0000, 1'b0, "R4");

        // R5 clamp below minimum
        cfg_write(8'd0, 1'b0, 1'b0);
        probe(32'h001F_FFFF, 1'b0, "R5");
        probe(32'h0020_0000, 1'b0, "R5");
        cfg_write(8'd1, 1'b0, 1'b0);
        probe(32'h0010_0000, 1'b0, "R5");

        // R6/R7 per-direction BIOS enables
        cfg_write(8'd16, 1'b1, 1'b0);
        probe(32'h000F_8000, 1'b0, "R6");
        probe(32'h000F_8000, 1'b1, "R7");
        cfg_write(8'd16, 1'b0, 1'b1);
        probe(32'h000F_8000, 1'b0, "R6");
        probe(32'h000F_8000, 1'b1, "R7");

        // R10 inputs ignored while cfg_we is low
        @(negedge clk);
        cfg_top_mb = 8'd100;
        cfg_bios_rd_cache = 1'b1;
        cfg_bios_wr_cache = 1'b0;
        repeat (4) @(negedge clk);
        probe(32'h0200_0000, 1'b0, "R10");
        probe(32'h000F_0000, 1'b0, "R10");
        probe(32'h000F_0000, 1'b1, "R10");

        // R11 two address changes inside one clock phase
        @(negedge clk);
        probe(32'h0000_1000, 1'b0, "R11");
        probe(32'h0F00_0000, 1'b0, "R11");

        // constrained random mix: R9 and the region rules
        for (int i = 0; i < 4000; i++) begin
            if ((i % 64) == 0)
                cfg_write(8'($urandom_range(0, 255)), 1'($urandom), 1'($urandom));
            kind = $urandom_range(0, 5);
            case (kind)
                0: a = $urandom;
                1: a = (m_top << 20) + 32'($urandom_range(0, 7)) - 32'd4;
                2: a = 32'hFFF8_0000 + 32'($urandom_range(0, 7)) - 32'd4;
                3: a = 32'h000F_0000 | 32'($urandom_range(0, 32'hFFFF));
                4: a = 32'($urandom_range(0, 32'h0CFF_FFFF));
                default: a = 32'hFFF0_0000 | 32'($urandom_range(0, 32'hF_FFFF));
            endcase
            @(negedge clk);
            probe(a, 1'($urandom), "R9");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule